// File: doc/BRIEF.md
# Streaming Write Flush Controller

This block sits between the output of a write FIFO and the write-data input of a memory access sequencer. It discards the incoming write stream whenever no write access is running. This covers the time before the first write, the time during a read access, and any time after software asks for the FIFO to be drained between accesses. Data passes to the sequencer again only from a chosen stream boundary onward. Depending on a parameter, that boundary is the next valid beat, the next start-of-packet beat or the next sync beat.

The controller watches the sequencer's access-start pulse, its write/read select and its done flag. From these and a flush request input it keeps an internal flush enable. A flush gate acts on that enable. Discarding starts in the same cycle the enable is seen high. It ends only when the enable is low and a qualifying boundary beat arrives, and that beat is the first one delivered. An optional channel window narrows which boundary beats qualify.

In sync mode the upstream FIFO carries the sync marker on its sop bit. The gate maps that bit back to sync and clears sop. The stream uses valid/ready with ready latency zero.

Top module: `wflush_top`

## Requirements
- R1: After reset the gate is discarding: snk_ready_o is 1 and src_valid_o is 0, whatever beat is offered.
- R2: While discarding, snk_ready_o is 1 and src_valid_o, src_sop_o, src_eop_o and src_sync_o are all 0.
- R3: While passing, every stream field at the source equals the sink field (after the sync remap of R10), and snk_ready_o equals src_ready_i.
- R4: An access-start pulse with acc_wr_i = 0 (read) sets the flush enable at the next clock edge. From the following cycle every beat is discarded, including a beat in the middle of a packet.
- R5: An access-start pulse with acc_wr_i = 1 (write) clears the flush enable at the next clock edge. The gate still resumes only at the boundary the mode selects. Start wins over a same-cycle flush request.
- R6: A flush request while acc_done_i = 1 sets the flush enable at the next clock edge, and discarding starts in the following cycle.
- R7: A flush request while acc_done_i = 0 is ignored, and the gate keeps passing.
- R8: In mode RESUME_VAL, with the enable low, the first valid beat is passed.
- R9: In mode RESUME_SOP, beats without sop are discarded until a beat with snk_sop_i = 1 arrives. That beat is the first one passed.
- R10: In mode RESUME_SYN, snk_sop_i carries sync. It resumes the gate and appears on src_sync_o, while src_sop_o stays 0 and snk_sync_i is ignored.
- R11: With the channel filter on, a boundary beat counts only if its channel lies in [CH_START, CH_START+CH_NUM). Other boundary beats are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_start_i | input | 1 | Access-start pulse from the sequencer side |
| acc_wr_i | input | 1 | 1 = write access, 0 = read access, sampled with acc_start_i |
| acc_done_i | input | 1 | High when no access is in progress |
| flush_req_i | input | 1 | Flush request pulse |
| snk_valid_i | input | 1 | Sink beat valid |
| snk_sop_i | input | 1 | Sink start of packet (sync in RESUME_SYN) |
| snk_eop_i | input | 1 | Sink end of packet |
| snk_sync_i | input | 1 | Sink sync marker |
| snk_chan_i | input | CH_W | Sink channel |
| snk_data_i | input | DATA_W | Sink data |
| snk_ready_o | output | 1 | Ready toward the write FIFO |
| src_valid_o | output | 1 | Source beat valid |
| src_sop_o | output | 1 | Source start of packet |
| src_eop_o | output | 1 | Source end of packet |
| src_sync_o | output | 1 | Source sync marker |
| src_chan_o | output | CH_W | Source channel |
| src_data_o | output | DATA_W | Source data |
| src_ready_i | input | 1 | Ready from the sequencer |

## Verification
The assertions check several properties on every cycle. A read start or an accepted idle flush request silences the source one cycle later. A write start clears the enable. Any valid beat that is not delivered is drained. A delivered beat mirrors the sink and its ready. In value mode a valid beat with the enable low is always delivered, and in sync mode sop never leaves the gate. Other behaviour depends on the order of beats and can only be shown by the bench's scenarios: skipping non-boundary beats, rejecting boundary beats outside the channel window, ignoring a request during an access, and the exact first beat delivered after resumption.

// File: rtl/wflush_pkg.sv
package wflush_pkg;
  typedef enum logic [1:0] {
    RESUME_VAL = 2'd0,
    RESUME_SOP = 2'd1,
    RESUME_SYN = 2'd2
  } resume_mode_e;
endpackage

// File: rtl/wflush_ctrl.sv
module wflush_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_start_i,
  input  logic acc_wr_i,
  input  logic acc_done_i,
  input  logic flush_req_i,
  output logic flush_en_o
);
  logic flush_en_q, flush_en_d;

  always_comb begin
    flush_en_d = flush_en_q;
    if (acc_start_i)                    flush_en_d = ~acc_wr_i;
    else if (flush_req_i && acc_done_i) flush_en_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flush_en_q <= 1'b1;
    else         flush_en_q <= flush_en_d;
  end

  assign flush_en_o = flush_en_q;
endmodule

// File: rtl/wflush_bound.sv
module wflush_bound
  import wflush_pkg::*;
#(
  parameter resume_mode_e MODE     = RESUME_SOP,
  parameter int unsigned  CH_W     = 4,
  parameter bit           USE_CHAN = 1'b0,
  parameter int unsigned  CH_START = 0,
  parameter int unsigned  CH_NUM   = 1
) (
  input  logic            valid_i,
  input  logic            sop_i,
  input  logic            sync_i,
  input  logic [CH_W-1:0] chan_i,
  output logic            sop_o,
  output logic            sync_o,
  output logic            bound_o
);
  localparam logic [CH_W:0] CH_LO = (CH_W+1)'(CH_START);
  localparam logic [CH_W:0] CH_HI = (CH_W+1)'(CH_START + CH_NUM);

  logic chan_ok;
  logic mark;

  generate
    if (USE_CHAN) begin : g_chan
      assign chan_ok = ({1'b0, chan_i} >= CH_LO) && ({1'b0, chan_i} < CH_HI);
    end else begin : g_nochan
      assign chan_ok = 1'b1;
    end

    if (MODE == RESUME_SYN) begin : g_syn
      // sync travels on the sop bit upstream
      assign sop_o  = 1'b0;
      assign sync_o = sop_i;
      assign mark   = sop_i;
    end else if (MODE == RESUME_SOP) begin : g_sop
      assign sop_o  = sop_i;
      assign sync_o = sync_i;
      assign mark   = sop_i;
    end else begin : g_val
      assign sop_o  = sop_i;
      assign sync_o = sync_i;
      assign mark   = 1'b1;
    end
  endgenerate

  assign bound_o = valid_i & mark & chan_ok;
endmodule

// File: rtl/wflush_gate.sv
module wflush_gate #(
  parameter int unsigned CH_W   = 4,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_en_i,
  input  logic              bound_i,
  input  logic              valid_i,
  input  logic              sop_i,
  input  logic              eop_i,
  input  logic              sync_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              valid_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              sync_o,
  output logic [CH_W-1:0]   chan_o,
  output logic [DATA_W-1:0] data_o,
  input  logic              ready_i,
  output logic              flushing_o
);
  logic flushing_q;
  logic drop;

  // enter at once, leave only on a boundary beat (which passes)
  assign drop = flush_en_i | (flushing_q & ~bound_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flushing_q <= 1'b1;
    else         flushing_q <= drop;
  end

  assign ready_o    = drop ? 1'b1 : ready_i;
  assign valid_o    = valid_i & ~drop;
  assign sop_o      = sop_i   & ~drop;
  assign eop_o      = eop_i   & ~drop;
  assign sync_o     = sync_i  & ~drop;
  assign chan_o     = chan_i;
  assign data_o     = data_i;
  assign flushing_o = flushing_q;
endmodule

// File: rtl/wflush_top.sv
module wflush_top
  import wflush_pkg::*;
#(
  parameter resume_mode_e MODE     = RESUME_SOP,
  parameter int unsigned  CH_W     = 4,
  parameter int unsigned  DATA_W   = 16,
  parameter bit           USE_CHAN = 1'b0,
  parameter int unsigned  CH_START = 0,
  parameter int unsigned  CH_NUM   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_start_i,
  input  logic              acc_wr_i,
  input  logic              acc_done_i,
  input  logic              flush_req_i,
  input  logic              snk_valid_i,
  input  logic              snk_sop_i,
  input  logic              snk_eop_i,
  input  logic              snk_sync_i,
  input  logic [CH_W-1:0]   snk_chan_i,
  input  logic [DATA_W-1:0] snk_data_i,
  output logic              snk_ready_o,
  output logic              src_valid_o,
  output logic              src_sop_o,
  output logic              src_eop_o,
  output logic              src_sync_o,
  output logic [CH_W-1:0]   src_chan_o,
  output logic [DATA_W-1:0] src_data_o,
  input  logic              src_ready_i
);
  logic flush_en;
  logic flushing;
  logic map_sop, map_sync, bound;

  wflush_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_start_i (acc_start_i),
    .acc_wr_i    (acc_wr_i),
    .acc_done_i  (acc_done_i),
    .flush_req_i (flush_req_i),
    .flush_en_o  (flush_en)
  );

  wflush_bound #(
    .MODE(MODE), .CH_W(CH_W), .USE_CHAN(USE_CHAN),
    .CH_START(CH_START), .CH_NUM(CH_NUM)
  ) u_bound (
    .valid_i (snk_valid_i),
    .sop_i   (snk_sop_i),
    .sync_i  (snk_sync_i),
    .chan_i  (snk_chan_i),
    .sop_o   (map_sop),
    .sync_o  (map_sync),
    .bound_o (bound)
  );

  wflush_gate #(.CH_W(CH_W), .DATA_W(DATA_W)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .flush_en_i (flush_en),
    .bound_i    (bound),
    .valid_i    (snk_valid_i),
    .sop_i      (map_sop),
    .eop_i      (snk_eop_i),
    .sync_i     (map_sync),
    .chan_i     (snk_chan_i),
    .data_i     (snk_data_i),
    .ready_o    (snk_ready_o),
    .valid_o    (src_valid_o),
    .sop_o      (src_sop_o),
    .eop_o      (src_eop_o),
    .sync_o     (src_sync_o),
    .chan_o     (src_chan_o),
    .data_o     (src_data_o),
    .ready_i    (src_ready_i),
    .flushing_o (flushing)
  );
endmodule

// File: rtl/wflush_chk.sv
module wflush_chk
  import wflush_pkg::*;
#(
  parameter resume_mode_e MODE   = RESUME_SOP,
  parameter int unsigned  DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              acc_start_i,
  input logic              acc_wr_i,
  input logic              acc_done_i,
  input logic              flush_req_i,
  input logic              flush_en,
  input logic              snk_valid_i,
  input logic [DATA_W-1:0] snk_data_i,
  input logic              snk_ready_o,
  input logic              src_valid_o,
  input logic              src_sop_o,
  input logic [DATA_W-1:0] src_data_o,
  input logic              src_ready_i
);
  AST_READ_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_start_i && !acc_wr_i |=> !src_valid_o && snk_ready_o); // R4

  AST_WRITE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_start_i && acc_wr_i |=> !flush_en); // R5

  AST_IDLE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_i && acc_done_i && !acc_start_i |=> !src_valid_o && snk_ready_o); // R6

  AST_BUSY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_i && !acc_done_i && !acc_start_i && !flush_en |=> !flush_en); // R7

  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snk_valid_i && !src_valid_o |-> snk_ready_o); // R2

  AST_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_valid_o |-> snk_ready_o == src_ready_i && src_data_o == snk_data_i); // R3

  AST_VAL_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MODE == RESUME_VAL && !flush_en && snk_valid_i |-> src_valid_o); // R8

  AST_SYN_NOSOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    MODE == RESUME_SYN && src_valid_o |-> !src_sop_o); // R10
endmodule

bind wflush_top wflush_chk #(.MODE(MODE), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_start_i (acc_start_i),
  .acc_wr_i    (acc_wr_i),
  .acc_done_i  (acc_done_i),
  .flush_req_i (flush_req_i),
  .flush_en    (flush_en),
  .snk_valid_i (snk_valid_i),
  .snk_data_i  (snk_data_i),
  .snk_ready_o (snk_ready_o),
  .src_valid_o (src_valid_o),
  .src_sop_o   (src_sop_o),
  .src_data_o  (src_data_o),
  .src_ready_i (src_ready_i)
);

// File: tb/sim_wflush_top.sv
`timescale 1ns/1ps
module sim_wflush_top;
  import wflush_pkg::*;
  localparam int CH_W = 4;
  localparam int DW   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic acc_start = 0, acc_wr = 0, acc_done = 1, flush_req = 0;
  logic v = 0, sop = 0, eop = 0, syn = 0, rdy = 1;
  logic [CH_W-1:0] ch = '0;
  logic [DW-1:0]   dat = '0;

  // index 0: SOP + channel window [2,4), 1: VAL, 2: SYN
  logic            o_rdy [3];
  logic            o_v   [3];
  logic            o_sop [3];
  logic            o_eop [3];
  logic            o_syn [3];
  logic [CH_W-1:0] o_ch  [3];
  logic [DW-1:0]   o_dat [3];

  wflush_top #(.MODE(RESUME_SOP), .CH_W(CH_W), .DATA_W(DW), .USE_CHAN(1'b1),
               .CH_START(2), .CH_NUM(2)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .acc_start_i(acc_start), .acc_wr_i(acc_wr),
    .acc_done_i(acc_done), .flush_req_i(flush_req), .snk_valid_i(v),
    .snk_sop_i(sop), .snk_eop_i(eop), .snk_sync_i(syn), .snk_chan_i(ch),
    .snk_data_i(dat), .snk_ready_o(o_rdy[0]), .src_valid_o(o_v[0]),
    .src_sop_o(o_sop[0]), .src_eop_o(o_eop[0]), .src_sync_o(o_syn[0]),
    .src_chan_o(o_ch[0]), .src_data_o(o_dat[0]), .src_ready_i(rdy));

  wflush_top #(.MODE(RESUME_VAL), .CH_W(CH_W), .DATA_W(DW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .acc_start_i(acc_start), .acc_wr_i(acc_wr),
    .acc_done_i(acc_done), .flush_req_i(flush_req), .snk_valid_i(v),
    .snk_sop_i(sop), .snk_eop_i(eop), .snk_sync_i(syn), .snk_chan_i(ch),
    .snk_data_i(dat), .snk_ready_o(o_rdy[1]), .src_valid_o(o_v[1]),
    .src_sop_o(o_sop[1]), .src_eop_o(o_eop[1]), .src_sync_o(o_syn[1]),
    .src_chan_o(o_ch[1]), .src_data_o(o_dat[1]), .src_ready_i(rdy));

  wflush_top #(.MODE(RESUME_SYN), .CH_W(CH_W), .DATA_W(DW)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .acc_start_i(acc_start), .acc_wr_i(acc_wr),
    .acc_done_i(acc_done), .flush_req_i(flush_req), .snk_valid_i(v),
    .snk_sop_i(sop), .snk_eop_i(eop), .snk_sync_i(syn), .snk_chan_i(ch),
    .snk_data_i(dat), .snk_ready_o(o_rdy[2]), .src_valid_o(o_v[2]),
    .src_sop_o(o_sop[2]), .src_eop_o(o_eop[2]), .src_sync_o(o_syn[2]),
    .src_chan_o(o_ch[2]), .src_data_o(o_dat[2]), .src_ready_i(rdy));

  int checks = 0, errors = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of inputs after a falling edge, settle, then let caller check
  task automatic beat(logic bv, logic bsop, logic beop, logic bsyn,
                      logic [CH_W-1:0] bch, logic [DW-1:0] bd);
    @(negedge clk);
    acc_start = 0; flush_req = 0;
    v = bv; sop = bsop; eop = beop; syn = bsyn; ch = bch; dat = bd;
    #1;
  endtask

  task automatic start(logic wr);
    @(negedge clk);
    acc_start = 1; acc_wr = wr; flush_req = 0; v = 0;
    #1;
  endtask

  task automatic req(logic done);
    @(negedge clk);
    acc_start = 0; flush_req = 1; acc_done = done; v = 0;
    #1;
  endtask

  task automatic t_reset();
    beat(1, 1, 1, 1, 4'd3, 16'h1111);
    for (int i = 0; i < 3; i++) begin
      chk("R1", "snk_ready", o_rdy[i], 1);
      chk("R1", "src_valid", o_v[i], 0);
    end
  endtask

  task automatic t_write_resume();
    acc_done = 1;
    start(1);
    acc_done = 0;
    beat(1, 0, 0, 1, 4'd2, 16'h2001);     // non-boundary for u0/u2
    chk("R9",  "u0 valid on non-sop", o_v[0], 0);
    chk("R2",  "u0 drain ready", o_rdy[0], 1);
    chk("R8",  "u1 first valid passes", o_v[1], 1);
    chk("R8",  "u1 data", o_dat[1], 16'h2001);
    chk("R10", "u2 sync input ignored", o_v[2], 0);
    beat(1, 1, 0, 0, 4'd5, 16'h2002);     // sop outside window
    chk("R11", "u0 sop out of window", o_v[0], 0);
    chk("R10", "u2 resumes on sop-carried sync", o_v[2], 1);
    chk("R10", "u2 sync out", o_syn[2], 1);
    chk("R10", "u2 sop cleared", o_sop[2], 0);
    beat(1, 1, 0, 0, 4'd3, 16'h2003);     // sop inside window
    chk("R9",  "u0 sop in window passes", o_v[0], 1);
    chk("R9",  "u0 sop out", o_sop[0], 1);
    chk("R11", "u0 channel", o_ch[0], 3);
    chk("R3",  "u0 data", o_dat[0], 16'h2003);
    rdy = 0;
    beat(1, 0, 1, 0, 4'd3, 16'h2004);
    chk("R3",  "u0 valid mid packet", o_v[0], 1);
    chk("R3",  "u0 eop", o_eop[0], 1);
    chk("R3",  "u0 ready follows sink", o_rdy[0], 0);
    rdy = 1;
  endtask

  task automatic t_busy_req();
    req(0);
    beat(1, 0, 0, 0, 4'd3, 16'h3001);
    chk("R7", "u0 still passes", o_v[0], 1);
    chk("R7", "u1 still passes", o_v[1], 1);
  endtask

  task automatic t_idle_req();
    req(1);
    beat(1, 1, 0, 0, 4'd3, 16'h4001);
    chk("R6", "u0 flushes even on sop", o_v[0], 0);
    chk("R6", "u1 flushes", o_v[1], 0);
    chk("R6", "u0 ready", o_rdy[0], 1);
  endtask

  task automatic t_read();
    start(1);
    beat(1, 1, 0, 0, 4'd2, 16'h5001);
    chk("R5", "u0 resumes after write start", o_v[0], 1);
    start(0);
    acc_done = 0;
    beat(1, 1, 1, 1, 4'd2, 16'h5002);
    chk("R4", "u0 read flush", o_v[0], 0);
    chk("R4", "u1 read flush", o_v[1], 0);
    chk("R2", "u0 sop low", o_sop[0], 0);
    chk("R2", "u0 eop low", o_eop[0], 0);
    chk("R2", "u0 sync low", o_syn[0], 0);
    chk("R2", "u2 sync low", o_syn[2], 0);
    chk("R2", "u2 ready", o_rdy[2], 1);
    acc_done = 1;
    // start beats a same-cycle request
    @(negedge clk);
    acc_start = 1; acc_wr = 1; flush_req = 1; v = 0;
    beat(0, 0, 0, 0, 4'd0, 16'h0);
    chk("R8", "u1 no valid no output", o_v[1], 0);
    beat(1, 0, 0, 0, 4'd7, 16'h5003);
    chk("R5", "u1 resumes, start beats request", o_v[1], 1);
    chk("R8", "u1 data", o_dat[1], 16'h5003);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_write_resume();
        t_busy_req();
        t_idle_req();
        t_read();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule